// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of up to four fans. Each fan's tachometer output is a pulse train with two pulses per revolution. For every channel the block counts ticks of a shared 90 kHz reference strobe between a rising pulse edge and the rising edge two pulses later. That count is one full revolution, in units of 11.111 µs. The result is a 16-bit unsigned number per channel. An all-ones value stands for a fan that is stopped or an input with no usable signal.

Software reads the results over a simple byte-wide register port: a select, a direction bit and an address. Each channel shows as a pair of bytes, the low byte first and the high byte at the next address. The two least significant bits of the low byte are replaced by an accuracy code. Reading a channel's low byte freezes that channel's high byte until the high byte is read, so that a split read always gives two halves of the same measurement. The registers are read-only, and write cycles leave them untouched.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, every channel reads 0xFFFF: both its low byte and its high byte return 0xFF.
- R2: The published count of a channel is the number of cycles with `ref_tick` high after its first synchronised rising tach edge, up to and including the cycle of the rising edge two pulses later. That later edge also opens the next interval. The count becomes readable without any read access.
- R3: Channel k (k = 0..3) has its low byte at address 0x28+2k and its high byte at 0x29+2k. A read of any other address returns 0x00. Read data appears on `rd_data` in the cycle after the read strobe, and it is 0x00 in cycles without a read.
- R4: The low byte is {count[7:2], acc}. acc is 2'b11 when count is at least 256 and 2'b01 when it is below 256. The code 2'b00 is never returned.
- R5: If 65535 ticks accumulate within an open interval before the closing edge, the channel reports 0xFFFF. The next rising edge starts a fresh interval, and a later full interval is again reported as a count.
- R6: A low-byte read of a channel freezes that channel's high byte at the matching value until the high byte of the same channel is read. Only after that read may the channel's visible value change.
- R7: An access with `bus_wr` high does not return data (`rd_data` is 0x00 afterwards). It does not alter any result and does not freeze any high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | 90 kHz reference strobe; each cycle high counts one tick |
| tach_in | input | 4 | Asynchronous tachometer inputs, one per fan |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | Access direction: 1 write, 0 read |
| bus_addr | input | 8 | Register address |
| rd_data | output | 8 | Read data, valid in the cycle after a read strobe |

## Verification
A rising tach level crosses two synchroniser flops and an edge flop. The measurement state is written on the third clock edge, and the readable copy is written on the fourth edge. After each tach pulse the bench therefore waits at least eight cycles before it reads anything back. Read data is registered once. It is sampled at the falling edge after the clock edge that captured the strobe, which keeps every check one cycle behind its access. Tick bursts never overlap a tach edge, so every expected count is exact and comes from the bench's own model of the interval rules.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef logic [CNT_W-1:0] count_t;

    localparam count_t      CNT_MAX    = '1;
    localparam count_t      FINE_MIN   = CNT_W'(256);
    localparam logic [1:0]  ACC_FINE   = 2'b11;
    localparam logic [1:0]  ACC_COARSE = 2'b01;

    // Interval state: no start yet, start edge seen, middle edge seen
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_MID  = 2'd2
    } phase_e;

    // Low byte as software sees it: upper six count bits plus accuracy code
    function automatic logic [BYTE_W-1:0] lsb_view(input count_t v);
        return {v[7:2], (v >= FINE_MIN) ? ACC_FINE : ACC_COARSE};
    endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] sr;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sr   = {s_q.sr[STAGES-2:0], tach_in};
        s_d.prev = s_q.sr[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise = s_q.sr[STAGES-1] & ~s_q.prev;

    // An edge lasts exactly one cycle (feeds the interval rule of R2)
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tach_period_meas.sv
module tach_period_meas
    import fan_tach_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   rise,
    output count_t period
);

    typedef struct packed {
        phase_e ph;
        count_t cnt;
        count_t res;
    } meas_t;

    meas_t m_d, m_q;
    count_t sum;

    always_comb begin
        m_d = m_q;
        // saturating tick count including this cycle's tick
        sum = (m_q.cnt == CNT_MAX) ? CNT_MAX : m_q.cnt + count_t'(tick);
        if (rise) begin
            case (m_q.ph)
                PH_IDLE: begin
                    m_d.ph  = PH_OPEN;
                    m_d.cnt = '0;
                end
                PH_OPEN: begin
                    m_d.ph  = PH_MID;
                    m_d.cnt = sum;
                end
                PH_MID: begin
                    m_d.res = sum;
                    m_d.cnt = '0;
                    m_d.ph  = PH_OPEN;
                end
                default: begin
                    m_d.ph  = PH_IDLE;
                    m_d.cnt = '0;
                end
            endcase
        end else begin
            m_d.cnt = sum;
        end
        // reaching the ceiling marks a stalled fan and drops the interval
        if (m_d.cnt == CNT_MAX && m_q.cnt != CNT_MAX) begin
            m_d.res = CNT_MAX;
            m_d.ph  = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.ph  <= PH_IDLE;
            m_q.cnt <= '0;
            m_q.res <= CNT_MAX;
        end else begin
            m_q <= m_d;
        end
    end

    assign period = m_q.res;

    // A saturated counter always goes with an all-ones result
    p_stall_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.cnt == CNT_MAX) |-> (m_q.res == CNT_MAX));

    // A saturated counter is never left open as a running interval
    p_stall_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.cnt == CNT_MAX) |-> (m_q.ph == PH_IDLE));

    // The result only moves on a closing edge or on a stall
    p_res_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && m_q.cnt != CNT_MAX && m_q.cnt + count_t'(tick) != CNT_MAX)
            |=> $stable(m_q.res));

endmodule

// File: rtl/tach_read_port.sv
module tach_read_port
    import fan_tach_pkg::*;
#(
    parameter int                 NUM_CH    = 4,
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h28
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  res,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    output logic [BYTE_W-1:0]             rd_data
);

    localparam int                CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] vis;
        logic [NUM_CH-1:0]            pend;
        logic [BYTE_W-1:0]            rdat;
    } port_t;

    port_t p_d, p_q;

    logic              rd_go;
    logic              hit;
    logic [ADDR_W-1:0] rel;
    logic [CH_W-1:0]   ch_sel;
    logic              hi_byte;

    always_comb begin
        rd_go   = bus_sel & ~bus_wr;
        rel     = bus_addr - BASE_ADDR;
        hit     = (bus_addr >= BASE_ADDR) && (rel < SPAN);
        ch_sel  = rel[CH_W:1];
        hi_byte = rel[0];
    end

    always_comb begin
        p_d      = p_q;
        p_d.rdat = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (!p_q.pend[k]) begin
                p_d.vis[k] = res[k];
            end
        end
        if (rd_go && hit) begin
            if (hi_byte) begin
                p_d.rdat         = p_q.vis[ch_sel][CNT_W-1:BYTE_W];
                p_d.pend[ch_sel] = 1'b0;
            end else begin
                p_d.rdat         = lsb_view(p_q.vis[ch_sel]);
                p_d.vis[ch_sel]  = p_q.vis[ch_sel];
                p_d.pend[ch_sel] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.vis  <= '1;
            p_q.pend <= '0;
            p_q.rdat <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rd_data = p_q.rdat;

    // Reads outside the window and write cycles return zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !hit) |=> (rd_data == '0));

    p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> (rd_data == '0));

    // A low-byte read never shows the reserved accuracy code
    p_acc_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hit && !hi_byte) |=> (rd_data[1:0] != 2'b00));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // Frozen high byte holds until released by its own read
        p_msb_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            p_q.pend[k] |=> $stable(p_q.vis[k][CNT_W-1:BYTE_W]));

        // Write cycles never arm the freeze
        p_write_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && !p_q.pend[k]) |=> !p_q.pend[k]);
    end

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int                 NUM_CH      = 4,
    parameter int                 ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 8'h28,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic [NUM_CH-1:0]  tach_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [BYTE_W-1:0]  rd_data
);

    logic [NUM_CH-1:0]            rise;
    logic [NUM_CH-1:0][CNT_W-1:0] res;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        tach_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tach_in (tach_in[k]),
            .rise    (rise[k])
        );

        tach_period_meas u_meas (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ref_tick),
            .rise   (rise[k]),
            .period (res[k])
        );
    end

    tach_read_port #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .res      (res),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/fan_tach_monitor_test.sv
module fan_tach_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_tick;
    logic [3:0] tach;
    logic       bus_sel;
    logic       bus_wr;
    logic [7:0] bus_addr;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the interval rules
    int          ph   [4];
    int          acc  [4];
    logic [15:0] expv [4];

    // vector fields: channel [31:24], ticks before middle edge [23:12], ticks after [11:0]
    localparam logic [31:0] VEC [8] = '{
        {8'd0, 12'd100,  12'd120},
        {8'd1, 12'd300,  12'd400},
        {8'd2, 12'd5,    12'd3},
        {8'd3, 12'd1000, 12'd1500},
        {8'd0, 12'd50,   12'd60},
        {8'd2, 12'd0,    12'd0},
        {8'd1, 12'd128,  12'd128},
        {8'd3, 12'd2,    12'd1}
    };

    always #5 clk = ~clk;

    fan_tach_monitor uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .tach_in  (tach),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rd_data  (rd_data)
    );

    function automatic logic [7:0] lsb_of(input logic [15:0] v);
        return {v[7:2], (v >= 16'd256) ? 2'b11 : 2'b01};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk) ref_tick = 1'b1;
            repeat (n) @(negedge clk);
            ref_tick = 1'b0;
            for (int c = 0; c < 4; c++) begin
                if (ph[c] != 0) begin
                    acc[c] += n;
                    if (acc[c] >= 65535) begin
                        expv[c] = 16'hFFFF;
                        ph[c]   = 0;
                        acc[c]  = 0;
                    end
                end
            end
        end
    endtask

    task automatic pulse(input int ch);
        @(negedge clk) tach[ch] = 1'b1;
        repeat (4) @(negedge clk);
        tach[ch] = 1'b0;
        repeat (4) @(negedge clk);
        case (ph[ch])
            0: begin ph[ch] = 1; acc[ch] = 0; end
            1: ph[ch] = 2;
            default: begin expv[ch] = 16'(acc[ch]); acc[ch] = 0; ph[ch] = 1; end
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        @(negedge clk);
        bus_sel  = 1'b0;
        d        = rd_data;
    endtask

    task automatic bus_write(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_sel  = 1'b0;
        bus_wr   = 1'b0;
        d        = rd_data;
    endtask

    function automatic logic [7:0] lo_addr(input int ch);
        return 8'(8'h28 + 2 * ch);
    endfunction

    task automatic check_ch(input string tag, input int ch);
        logic [7:0] d;
        bus_read(lo_addr(ch), d);
        check($sformatf("%s ch%0d low", tag, ch), d, lsb_of(expv[ch]));
        bus_read(lo_addr(ch) + 8'd1, d);
        check($sformatf("%s ch%0d high", tag, ch), d, expv[ch][15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] old;
        for (int c = 0; c < 4; c++) begin
            ph[c] = 0; acc[c] = 0; expv[c] = 16'hFFFF;
        end
        rst_n = 1'b0; ref_tick = 1'b0; tach = '0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: every channel all ones out of reset
        for (int c = 0; c < 4; c++) check_ch("R1 reset", c);

        // R3: addresses outside the window read zero
        bus_read(8'h27, d); check("R3 addr 27", d, 8'h00);
        bus_read(8'h30, d); check("R3 addr 30", d, 8'h00);
        bus_read(8'h00, d); check("R3 addr 00", d, 8'h00);

        // R2 / R4: vector table, one revolution per entry
        for (int v = 0; v < 8; v++) begin
            int ch;
            ch = int'(VEC[v][31:24]);
            pulse(ch);
            ticks(int'(VEC[v][23:12]));
            pulse(ch);
            ticks(int'(VEC[v][11:0]));
            pulse(ch);
            check_ch($sformatf("R2 R4 vec%0d", v), ch);
        end

        // R6: low byte read freezes high byte across a new measurement
        old = expv[1];
        bus_read(lo_addr(1), d);
        check("R6 low before update", d, lsb_of(old));
        pulse(1); ticks(900); pulse(1); ticks(900); pulse(1);
        bus_read(lo_addr(1) + 8'd1, d);
        check("R6 frozen high", d, old[15:8]);
        check("R6 value moved", (old != expv[1]) ? 8'h01 : 8'h00, 8'h01);
        check_ch("R6 released", 1);

        // R7: a write neither returns data nor arms the freeze
        old = expv[3];
        bus_write(lo_addr(3), d);
        check("R7 write data", d, 8'h00);
        pulse(3); ticks(2000); pulse(3); ticks(10); pulse(3);
        check("R7 value moved", (old[15:8] != expv[3][15:8]) ? 8'h01 : 8'h00, 8'h01);
        bus_read(lo_addr(3) + 8'd1, d);
        check("R7 high not frozen", d, expv[3][15:8]);
        bus_write(lo_addr(3) + 8'd1, d);
        check_ch("R7 after writes", 3);

        // R5: long tick run stalls every open interval
        ticks(65540);
        repeat (4) @(negedge clk);
        for (int c = 0; c < 4; c++) check_ch("R5 stall", c);
        pulse(2); ticks(500); pulse(2); ticks(700); pulse(2);
        check("R5 model recount", (expv[2] == 16'd1200) ? 8'h01 : 8'h00, 8'h01);
        check_ch("R5 recovery", 2);
        check_ch("R5 still stalled", 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule